// File: doc/BRIEF.md
# Width-Adapting Single-Channel DMA Engine

This block is one DMA channel that copies a programmed number of data items between a peripheral-side address and a memory-side address. A direction bit picks which side is read and which is written. Each side has its own data width of 8, 16 or 32 bits. Every item is one read on the source side followed by one write on the destination side. Each address pointer advances by its own width in bytes.

When the destination is wider than the source, the value is zero-extended. When it is narrower, the upper bits are dropped. Data on the bus is right-aligned, and byte order is little-endian.

Software programs the channel through a small register-style write port and then issues a start command. The engine drives a request/grant bus master that has a size field. It raises a sticky completion flag once the last item has been written.

Configuration map, as word index on `cfg_addr`:
- 0: peripheral address.
- 1: memory address.
- 2: item count.
- 3: control.
  - bit 0: direction.
  - bits 2:1: peripheral width code.
  - bits 4:3: memory width code.
  - bit 5: peripheral increment.
  - bit 6: memory increment.
- 4: command.
  - bit 0: start.
  - bit 1: clear completion.

Top module: `dma_width_chan`

## Requirements
- R1: After reset the channel is idle: `busy`, `done` and `bus_req` are all 0.
- R2: With control bit 0 set, the memory side is read and the peripheral side is written. With it clear, the peripheral side is read and the memory side is written. Each side uses its own width code and increment bit.
- R3: Each item is one read request (`bus_we`=0) at the source pointer, then one write request (`bus_we`=1) at the destination pointer. The write is issued only after `bus_rvalid` has returned the read data. A request and its address, size and write-enable are held until `bus_gnt`.
- R4: When the destination is wider than the source, the write data holds the source value in the low bits and zeros above the source width.
- R5: When the destination is narrower than the source, only the low destination-width bits of the read data are written. Bits of `bus_rdata` above the source width are never written.
- R6: With increment enabled, a pointer advances after each item by its own width in bytes (1, 2 or 4).
- R7: With increment disabled, that side's address stays the same for every item.
- R8: Exactly the programmed count of items is moved. `done` rises after the last write is granted, and `busy` is 0 whenever `done` is 1.
- R9: A start with an item count of 0 issues no bus request and sets `done` on the next clock edge.
- R10: `done` stays set until a command write with bit 1 set clears it. A new start also clears it.
- R11: While `busy` is 1, writes to the address, count and control registers, and start commands, are ignored. A later start with no reprogramming repeats the original transfer.
- R12: Width codes are 0 = byte, 1 = halfword, 2 = word, and code 3 acts as word. `bus_size` carries codes 0, 1 or 2 for the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| bus_req | output | 1 | Bus request, held until grant |
| bus_addr | output | 32 | Byte address of the access |
| bus_size | output | 2 | Access size code (0 byte, 1 half, 2 word) |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_wdata | output | 32 | Right-aligned write data |
| bus_gnt | input | 1 | Request accepted this cycle |
| bus_rdata | input | 32 | Right-aligned read data |
| bus_rvalid | input | 1 | Read data valid pulse |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |

## Verification
A wrong pointer or remaining-count value shows at the bus on the very next request. The address seen differs from base plus item index times width, or the number of granted requests differs from the count, before `done` rises. A wrong capture or width fit shows in the data of the first write after the bad read, one cycle after `bus_rvalid`. A corrupted busy or done state shows either as configuration writes taking effect during a transfer, seen on the next start, or as `done` and `busy` set together.

// File: rtl/dma_wc_pkg.sv
package dma_wc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_REQ  = 2'd1,
    ST_RD_WAIT = 2'd2,
    ST_WR_REQ  = 2'd3
  } chan_state_e;

  typedef struct packed {
    logic       mem_is_src;
    logic [1:0] per_sz;
    logic [1:0] mem_sz;
    logic       per_inc;
    logic       mem_inc;
  } chan_ctl_t;

  localparam logic [2:0] REG_PER_ADDR = 3'd0;
  localparam logic [2:0] REG_MEM_ADDR = 3'd1;
  localparam logic [2:0] REG_COUNT    = 3'd2;
  localparam logic [2:0] REG_CTRL     = 3'd3;
  localparam logic [2:0] REG_CMD      = 3'd4;

  // code 3 behaves as a word access
  function automatic logic [1:0] norm_size(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (norm_size(code))
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_wc_cfg.sv
module dma_wc_cfg
  import dma_wc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int CFG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              busy,
  output logic [ADDR_W-1:0] per_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CNT_W-1:0]  count,
  output chan_ctl_t         ctl,
  output logic              start_pulse,
  output logic              clr_pulse
);

  localparam int CTL_W = $bits(chan_ctl_t);

  logic      wr_ok;
  logic      per_en, mem_en, cnt_en, ctl_en;
  chan_ctl_t ctl_in;
  logic      cfg_unused;

  assign wr_ok  = cfg_we & ~busy;
  assign per_en = wr_ok & (cfg_addr == REG_PER_ADDR);
  assign mem_en = wr_ok & (cfg_addr == REG_MEM_ADDR);
  assign cnt_en = wr_ok & (cfg_addr == REG_COUNT);
  assign ctl_en = wr_ok & (cfg_addr == REG_CTRL);

  assign ctl_in.mem_is_src = cfg_wdata[0];
  assign ctl_in.per_sz     = cfg_wdata[2:1];
  assign ctl_in.mem_sz     = cfg_wdata[4:3];
  assign ctl_in.per_inc    = cfg_wdata[5];
  assign ctl_in.mem_inc    = cfg_wdata[6];

  assign start_pulse = wr_ok  & (cfg_addr == REG_CMD) & cfg_wdata[0];
  assign clr_pulse   = cfg_we & (cfg_addr == REG_CMD) & cfg_wdata[1];

  assign cfg_unused = ^cfg_wdata[CFG_W-1:CTL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_addr <= '0;
      mem_addr <= '0;
      count    <= '0;
      ctl      <= '0;
    end else begin
      if (per_en) per_addr <= cfg_wdata[ADDR_W-1:0];
      if (mem_en) mem_addr <= cfg_wdata[ADDR_W-1:0];
      if (cnt_en) count    <= cfg_wdata[CNT_W-1:0];
      if (ctl_en) ctl      <= ctl_in;
    end
  end

endmodule

// File: rtl/dma_wc_fit.sv
module dma_wc_fit
  import dma_wc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        src_sz,
  input  logic [1:0]        dst_sz,
  output logic [DATA_W-1:0] fit_data
);

  localparam int LANES = DATA_W / 8;

  logic [2:0] src_b, dst_b, keep_b;

  assign src_b  = size_bytes(src_sz);
  assign dst_b  = size_bytes(dst_sz);
  assign keep_b = (src_b < dst_b) ? src_b : dst_b;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_on;
    assign lane_on = (g < int'(keep_b));
    assign fit_data[g*8 +: 8] = lane_on ? rd_data[g*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/dma_wc_seq.sv
module dma_wc_seq
  import dma_wc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] per_addr,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [CNT_W-1:0]  count,
  input  chan_ctl_t         ctl,
  input  logic              start,
  input  logic              clr,
  input  logic              bus_gnt,
  input  logic              bus_rvalid,
  input  logic [DATA_W-1:0] fit_data,
  output logic [1:0]        src_sz,
  output logic [1:0]        dst_sz,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              busy,
  output logic              done
);

  chan_state_e       state, state_n;
  logic [ADDR_W-1:0] src_ptr, src_ptr_n, dst_ptr, dst_ptr_n;
  logic [CNT_W-1:0]  remain, remain_n;
  logic [DATA_W-1:0] wbuf;
  logic              done_n;
  logic              ptr_en, wbuf_en;

  logic [ADDR_W-1:0] src_base, dst_base, src_step, dst_step;
  logic              src_inc, dst_inc;

  // role selection from the direction bit
  assign src_base = ctl.mem_is_src ? mem_addr    : per_addr;
  assign dst_base = ctl.mem_is_src ? per_addr    : mem_addr;
  assign src_sz   = ctl.mem_is_src ? ctl.mem_sz  : ctl.per_sz;
  assign dst_sz   = ctl.mem_is_src ? ctl.per_sz  : ctl.mem_sz;
  assign src_inc  = ctl.mem_is_src ? ctl.mem_inc : ctl.per_inc;
  assign dst_inc  = ctl.mem_is_src ? ctl.per_inc : ctl.mem_inc;

  assign src_step = src_inc ? ADDR_W'(size_bytes(src_sz)) : '0;
  assign dst_step = dst_inc ? ADDR_W'(size_bytes(dst_sz)) : '0;

  always_comb begin
    state_n   = state;
    src_ptr_n = src_ptr;
    dst_ptr_n = dst_ptr;
    remain_n  = remain;
    done_n    = done;
    ptr_en    = 1'b0;
    wbuf_en   = 1'b0;
    if (clr) done_n = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (count == '0) begin
            done_n = 1'b1;
          end else begin
            done_n    = 1'b0;
            src_ptr_n = src_base;
            dst_ptr_n = dst_base;
            remain_n  = count;
            ptr_en    = 1'b1;
            state_n   = ST_RD_REQ;
          end
        end
      end
      ST_RD_REQ: begin
        if (bus_gnt) state_n = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (bus_rvalid) begin
          wbuf_en = 1'b1;
          state_n = ST_WR_REQ;
        end
      end
      ST_WR_REQ: begin
        if (bus_gnt) begin
          src_ptr_n = src_ptr + src_step;
          dst_ptr_n = dst_ptr + dst_step;
          remain_n  = remain - 1'b1;
          ptr_en    = 1'b1;
          if (remain == CNT_W'(1)) begin
            state_n = ST_IDLE;
            done_n  = 1'b1;
          end else begin
            state_n = ST_RD_REQ;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      src_ptr <= '0;
      dst_ptr <= '0;
      remain  <= '0;
      wbuf    <= '0;
    end else begin
      state <= state_n;
      done  <= done_n;
      if (ptr_en) begin
        src_ptr <= src_ptr_n;
        dst_ptr <= dst_ptr_n;
        remain  <= remain_n;
      end
      if (wbuf_en) wbuf <= fit_data;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign bus_req   = (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign bus_we    = (state == ST_WR_REQ);
  assign bus_addr  = bus_we ? dst_ptr : src_ptr;
  assign bus_size  = norm_size(bus_we ? dst_sz : src_sz);
  assign bus_wdata = bus_we ? wbuf : '0;

endmodule

// File: rtl/dma_width_chan.sv
module dma_width_chan
  import dma_wc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_rvalid,
  output logic              busy,
  output logic              done
);

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [ADDR_W-1:0] per_addr, mem_addr;
  logic [CNT_W-1:0]  count;
  chan_ctl_t         ctl;
  logic              start_pulse, clr_pulse;
  logic [1:0]        src_sz, dst_sz;
  logic [DATA_W-1:0] fit_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  dma_wc_cfg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(32)) i_cfg (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .busy        (busy),
    .per_addr    (per_addr),
    .mem_addr    (mem_addr),
    .count       (count),
    .ctl         (ctl),
    .start_pulse (start_pulse),
    .clr_pulse   (clr_pulse)
  );

  dma_wc_fit #(.DATA_W(DATA_W)) i_fit (
    .rd_data  (bus_rdata),
    .src_sz   (src_sz),
    .dst_sz   (dst_sz),
    .fit_data (fit_data)
  );

  dma_wc_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .per_addr   (per_addr),
    .mem_addr   (mem_addr),
    .count      (count),
    .ctl        (ctl),
    .start      (start_pulse),
    .clr        (clr_pulse),
    .bus_gnt    (bus_gnt),
    .bus_rvalid (bus_rvalid),
    .fit_data   (fit_data),
    .src_sz     (src_sz),
    .dst_sz     (dst_sz),
    .bus_req    (bus_req),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .busy       (busy),
    .done       (done)
  );

endmodule

// File: rtl/dma_wc_checker.sv
module dma_wc_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rvalid,
  input logic              busy,
  input logic              done
);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size)));

  assert_write_follows_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_req && bus_rvalid) |=> (bus_req && bus_we));

  assert_req_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);

  assert_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |->
      ((bus_size == 2'd0) ? (bus_wdata[DATA_W-1:8] == '0) :
       (bus_size == 2'd1) ? (bus_wdata[DATA_W-1:16] == '0) : 1'b1));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_size_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_size != 2'd3));

endmodule

bind dma_width_chan dma_wc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_size   (bus_size),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .busy       (busy),
  .done       (done)
);

// File: tb/test_dma_width_chan.sv
`timescale 1ns/1ps
module test_dma_width_chan;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        bus_req;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic        bus_gnt;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        busy;
  logic        done;

  int n_cmp = 0;
  int n_bad = 0;
  int stall = 0;

  logic [31:0] log_addr  [64];
  logic [1:0]  log_size  [64];
  logic        log_we    [64];
  logic [31:0] log_wdata [64];
  int          log_n = 0;

  dma_width_chan i_dma_width_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_size(bus_size), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] hash(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'hC3A55A3C;
  endfunction

  function automatic logic [31:0] wmask(input int bytes);
    return (bytes >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (bytes * 8)) - 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bus slave: grant after 'stall' waiting cycles, read data one cycle after grant
  initial begin
    int age;
    logic rd_pend;
    logic [31:0] pend_addr;
    age = 0; rd_pend = 1'b0; pend_addr = '0;
    bus_gnt = 1'b0; bus_rvalid = 1'b0; bus_rdata = '0;
    forever begin
      @(negedge clk);
      bus_gnt = 1'b0;
      bus_rvalid = 1'b0;
      if (!rst_n) begin
        age = 0; rd_pend = 1'b0;
      end else if (rd_pend) begin
        bus_rvalid = 1'b1;
        bus_rdata = hash(pend_addr);
        rd_pend = 1'b0;
      end else if (bus_req) begin
        if (age >= stall) begin
          bus_gnt = 1'b1;
          age = 0;
          if (log_n < 64) begin
            log_addr[log_n] = bus_addr;
            log_size[log_n] = bus_size;
            log_we[log_n] = bus_we;
            log_wdata[log_n] = bus_wdata;
          end
          log_n++;
          if (!bus_we) begin
            rd_pend = 1'b1;
            pend_addr = bus_addr;
          end
        end else begin
          age++;
        end
      end
    end
  end

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
  endtask

  task automatic wait_done(input string req);
    int t;
    t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL %s: actual timeout expected done", req);
    end
  endtask

  function automatic int bytes_of(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  // checks the logged bus trace of one transfer against the requirements
  task automatic check_trace(input string tag, input logic dir, input logic [1:0] psz,
                             input logic [1:0] msz, input logic pinc, input logic minc,
                             input logic [31:0] pa, input logic [31:0] ma, input int cnt);
    logic [1:0] ssz, dsz;
    logic sinc, dinc;
    logic [31:0] sa, da, exp_d;
    int sb, db, kb;
    ssz = dir ? msz : psz;  dsz = dir ? psz : msz;
    sinc = dir ? minc : pinc; dinc = dir ? pinc : minc;
    sa = dir ? ma : pa;     da = dir ? pa : ma;
    sb = bytes_of(ssz); db = bytes_of(dsz);
    kb = (sb < db) ? sb : db;
    chk({tag, " R8 item count"}, log_n, 2 * cnt);
    for (int i = 0; i < cnt && 2 * i + 1 < 64; i++) begin
      chk({tag, " R3 read we"}, {31'b0, log_we[2*i]}, 32'd0);
      chk({tag, " R2 R6 R7 src addr"}, log_addr[2*i], sinc ? sa + i * sb : sa);
      chk({tag, " R12 src size"}, {30'b0, log_size[2*i]}, {30'b0, (ssz == 2'd3) ? 2'd2 : ssz});
      chk({tag, " R3 write we"}, {31'b0, log_we[2*i+1]}, 32'd1);
      chk({tag, " R2 R6 R7 dst addr"}, log_addr[2*i+1], dinc ? da + i * db : da);
      chk({tag, " R12 dst size"}, {30'b0, log_size[2*i+1]}, {30'b0, (dsz == 2'd3) ? 2'd2 : dsz});
      exp_d = hash(sinc ? sa + i * sb : sa) & wmask(kb);
      chk({tag, " R4 R5 wdata"}, log_wdata[2*i+1], exp_d);
    end
  endtask

  task automatic run_xfer(input string tag, input logic dir, input logic [1:0] psz,
                          input logic [1:0] msz, input logic pinc, input logic minc,
                          input logic [31:0] pa, input logic [31:0] ma, input int cnt);
    cfg_write(3'd0, pa);
    cfg_write(3'd1, ma);
    cfg_write(3'd2, cnt);
    cfg_write(3'd3, {25'b0, minc, pinc, msz, psz, dir});
    log_n = 0;
    cfg_write(3'd4, 32'h1);
    wait_done(tag);
    @(negedge clk);
    chk({tag, " R8 busy low at end"}, {31'b0, busy}, 32'd0);
    check_trace(tag, dir, psz, msz, pinc, minc, pa, ma, cnt);
    cfg_write(3'd4, 32'h2);
  endtask

  task automatic t_reset;
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 bus_req", {31'b0, bus_req}, 32'd0);
  endtask

  task automatic t_zero_count;
    cfg_write(3'd2, 32'd0);
    log_n = 0;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 32'h1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    chk("R9 done next edge", {31'b0, done}, 32'd1);
    chk("R9 not busy", {31'b0, busy}, 32'd0);
    repeat (4) @(negedge clk);
    chk("R9 no bus request", log_n, 32'd0);
    // R10: sticky until cleared
    chk("R10 done sticky", {31'b0, done}, 32'd1);
    cfg_write(3'd4, 32'h2);
    chk("R10 done cleared", {31'b0, done}, 32'd0);
  endtask

  task automatic t_busy_ignore;
    stall = 3;
    cfg_write(3'd0, 32'h0000_0100);
    cfg_write(3'd1, 32'h0000_2000);
    cfg_write(3'd2, 32'd3);
    cfg_write(3'd3, {25'b0, 1'b1, 1'b1, 2'd2, 2'd2, 1'b0});
    log_n = 0;
    cfg_write(3'd4, 32'h1);
    chk("R11 busy after start", {31'b0, busy}, 32'd1);
    cfg_write(3'd0, 32'h0000_9990);
    cfg_write(3'd1, 32'h0000_7770);
    cfg_write(3'd2, 32'd7);
    cfg_write(3'd3, {25'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1});
    cfg_write(3'd4, 32'h1);
    wait_done("R11 first run");
    @(negedge clk);
    check_trace("R11 first", 1'b0, 2'd2, 2'd2, 1'b1, 1'b1, 32'h100, 32'h2000, 3);
    cfg_write(3'd4, 32'h2);
    log_n = 0;
    cfg_write(3'd4, 32'h1);
    wait_done("R11 rerun");
    @(negedge clk);
    check_trace("R11 rerun", 1'b0, 2'd2, 2'd2, 1'b1, 1'b1, 32'h100, 32'h2000, 3);
    cfg_write(3'd4, 32'h2);
    stall = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    // byte memory -> word peripheral, zero extension, R2 R4 R6
    run_xfer("R4 b2w", 1'b1, 2'd2, 2'd0, 1'b1, 1'b1, 32'h4000_0000, 32'h2000_0001, 4);
    // word peripheral -> byte memory, truncation, R5
    run_xfer("R5 w2b", 1'b0, 2'd2, 2'd0, 1'b1, 1'b1, 32'h4000_0100, 32'h2000_0300, 4);
    // word -> half, with a stalling bus
    stall = 2;
    run_xfer("R5 w2h", 1'b1, 2'd1, 2'd2, 1'b1, 1'b1, 32'h4000_0200, 32'h2000_0400, 3);
    stall = 0;
    // half -> word, peripheral fixed, R7
    run_xfer("R7 fixed", 1'b0, 2'd1, 2'd2, 1'b0, 1'b1, 32'h4000_0010, 32'h2000_0800, 4);
    // code 3 acts as word, memory side fixed, R12
    run_xfer("R12 code3", 1'b1, 2'd1, 2'd3, 1'b1, 1'b0, 32'h4000_0020, 32'h2000_0900, 2);
    // single item, byte to byte
    run_xfer("R8 single", 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 32'h4000_0033, 32'h2000_0a00, 1);
    t_zero_count();
    t_busy_ignore();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule